// File: doc/BRIEF.md
# Inbound Requester-to-Group Authorization

This block sits on the inbound side of a PCIe root port. It classifies each request arriving from a device and produces a verdict. Every request carries a 16-bit requester ID (bus/device/function). An on-chip table maps that ID to an 8-bit isolation group. Memory writes are further decoded. A write that lands in one of two small message-signalled interrupt (MSI) windows is treated as an MSI. Any other memory access is a DMA access, and for DMA one address bit picks which of the group's two DMA windows applies.

For an MSI the block forms an interrupt number out of 2048 from the address and the data word. It then reads the owning group stored in a per-interrupt descriptor table. The interrupt is authorized only when that owner equals the requester's group. A rejected interrupt raises a sticky violation flag, and the requester ID and interrupt number of the first rejection are kept for later inspection. Error messages only go through the requester lookup. Both tables are loaded through a simple write port. Every request gets its result exactly one clock later. Address translation and interrupt delivery happen downstream and are not part of this block.

Top module: `req_group_auth`

## Requirements
- R1: After reset all result outputs are 0, the violation flag is 0, and every entry of both tables reads as group 0.
- R2: A request presented with `req_valid` high yields `res_valid` high one clock later. `res_group` then equals the requester-table entry indexed by the low 8 bits of `req_rid`.
- R3: A table write (`cfg_we` high) goes to the requester table when `cfg_tsel` is 0, at entry `cfg_addr[7:0]`, and to the descriptor table when `cfg_tsel` is 1, at entry `cfg_addr[10:0]`. A lookup in the same cycle as a write to the same entry sees the old value, and later lookups see the new value.
- R4: A memory read (`req_kind` 2'b00), and a memory write (2'b01) that hits no MSI window, are DMA: `res_msi`=0, `res_auth`=1 and `res_win` = address bit 59.
- R5: A memory write is an MSI when address bits [63:16] equal 48'h0000_0000_FFFF (the top 64 KB of 32-bit space) or equal `msi_hi_page`. A memory read to those addresses is still DMA.
- R6: The interrupt number of an MSI is (address bits [15:5] + `req_data`) modulo 2048.
- R7: An MSI has `res_auth`=1 exactly when the descriptor-table entry for its interrupt number equals the requester's group.
- R8: A request whose `req_kind` bit 1 is set is an error message: `res_msi`=0, `res_win`=0, `res_auth`=1, and `res_group` comes from the requester lookup.
- R9: The first rejected MSI sets `viol_flag` and captures its requester ID and interrupt number in the same clock as its result. The flag stays set until reset, and later rejections leave the captured values unchanged.
- R10: `res_irq` is 0 for every result that is not an MSI. `res_valid` is 0 one clock after a cycle with no request, and all result fields are then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_tsel | input | 1 | Table select: 0 requester table, 1 descriptor table |
| cfg_addr | input | 11 | Table entry index |
| cfg_wdata | input | 8 | Group number to store |
| msi_hi_page | input | 48 | Address bits [63:16] of the high MSI window |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 00 read, 01 write, 1x error message |
| req_rid | input | 16 | Requester bus/device/function |
| req_addr | input | 64 | Request address |
| req_data | input | 32 | Write data (MSI data word) |
| res_valid | output | 1 | Result present |
| res_kind | output | 2 | Kind of the classified request |
| res_group | output | 8 | Requester group |
| res_win | output | 1 | DMA window select |
| res_msi | output | 1 | Request was an MSI |
| res_irq | output | 11 | Interrupt number (MSI only) |
| res_auth | output | 1 | Request authorized |
| viol_flag | output | 1 | Sticky rejected-MSI flag |
| viol_rid | output | 16 | Requester ID of first rejected MSI |
| viol_irq | output | 11 | Interrupt number of first rejected MSI |

## Verification
Some properties are checked by assertions on every clock. These are the one-cycle result latency, the unconditional authorization of DMA and error messages, window select following bit 59, a zero interrupt number outside MSIs, the absence of MSIs on reads, and the stickiness of the violation flag with its frozen capture fields. Other behaviour depends on table contents and arithmetic, so only the bench scenarios can show it. This covers the group each requester resolves to, the interrupt number wrap-around, the owner comparison, the old-value result of a write and lookup in the same cycle, and which rejection the capture registers hold.

// File: rtl/rga_pkg.sv
// Package: shared request-kind encoding and default sizes for the
// requester-to-group authorization block.
package rga_pkg;

    // Request kinds as presented on req_kind; bit 1 set marks a message.
    typedef enum logic [1:0] {
        KIND_MEM_RD  = 2'b00,
        KIND_MEM_WR  = 2'b01,
        KIND_MSG     = 2'b10,
        KIND_MSG_ALT = 2'b11
    } req_kind_e;

    localparam int DEF_RID_W  = 16;
    localparam int DEF_GRP_W  = 8;
    localparam int DEF_IDX_W  = 8;
    localparam int DEF_IRQ_W  = 11;
    localparam int DEF_ADDR_W = 64;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_WIN_BIT = 59;
    localparam int DEF_IRQ_LSB = 5;

endpackage

// File: rtl/rga_group_table.sv
// Module: rga_group_table
// Direct-mapped table of group numbers with one write port and one
// combinational read port. Assumes the caller registers the read data.
// A read in the same cycle as a write to the same entry returns the old value.
module rga_group_table #(
    parameter int IDX_W = 8,
    parameter int DAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DAT_W-1:0] wr_dat,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DAT_W-1:0] rd_dat
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DAT_W-1:0] mem [DEPTH];

    // Clear every entry on reset, otherwise store one entry per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_dat;
        end
    end

    // Read port: content before this cycle's write.
    assign rd_dat = mem[rd_idx];

endmodule

// File: rtl/rga_addr_decode.sv
// Module: rga_addr_decode
// Purely combinational classifier of one inbound request. Decides MSI vs
// DMA for memory writes, picks the DMA window from one address bit and
// forms the interrupt number. Assumes a 64 KB MSI window whose size is
// implied by the interrupt field position and width.
module rga_addr_decode
    import rga_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int DATA_W  = DEF_DATA_W,
    parameter int IRQ_W   = DEF_IRQ_W,
    parameter int IRQ_LSB = DEF_IRQ_LSB,
    parameter int WIN_BIT = DEF_WIN_BIT,
    localparam int PAGE_LSB = IRQ_LSB + IRQ_W,
    localparam int PAGE_W   = ADDR_W - PAGE_LSB
) (
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic [PAGE_W-1:0] hi_page,
    output logic              is_msg,
    output logic              is_msi,
    output logic              win_sel,
    output logic [IRQ_W-1:0]  irq
);
    // Page index of the window just below 4 GB.
    localparam logic [PAGE_W-1:0] LO_PAGE = PAGE_W'((64'd1 << (32 - PAGE_LSB)) - 64'd1);

    logic [PAGE_W-1:0] page;
    logic [IRQ_W-1:0]  addr_field;
    logic              page_hit;

    // Split the address into page number and in-window interrupt field.
    always_comb begin
        page       = addr[ADDR_W-1:PAGE_LSB];
        addr_field = IRQ_W'(addr[PAGE_LSB-1:0] >> IRQ_LSB);
        page_hit   = (page == LO_PAGE) || (page == hi_page);
    end

    // Classify the request and derive window and interrupt number.
    always_comb begin
        is_msg  = kind[1];
        is_msi  = (kind == KIND_MEM_WR) && page_hit;
        win_sel = !is_msg && !is_msi && addr[WIN_BIT];
        irq     = is_msi ? IRQ_W'(DATA_W'(addr_field) + data) : '0;
    end

endmodule

// File: rtl/rga_viol_log.sv
// Module: rga_viol_log
// Sticky record of the first rejected interrupt. Assumes reject is a
// single-cycle qualifier aligned with the rid and irq inputs.
module rga_viol_log #(
    parameter int RID_W = 16,
    parameter int IRQ_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reject,
    input  logic [RID_W-1:0] rid,
    input  logic [IRQ_W-1:0] irq,
    output logic             flag,
    output logic [RID_W-1:0] rid_q,
    output logic [IRQ_W-1:0] irq_q
);
    // Set the flag and capture details only on the first rejection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            rid_q <= '0;
            irq_q <= '0;
        end else if (reject && !flag) begin
            flag  <= 1'b1;
            rid_q <= rid;
            irq_q <= irq;
        end
    end

endmodule

// File: rtl/req_group_auth.sv
// Module: req_group_auth
// Top of the inbound requester-to-group authorization block. Looks up the
// requester group, classifies the request, checks MSI ownership and
// registers one result per request with a fixed one-cycle latency.
// Assumes IDX_W <= IRQ_W so one table index port serves both tables.
module req_group_auth
    import rga_pkg::*;
#(
    parameter int RID_W   = DEF_RID_W,
    parameter int GRP_W   = DEF_GRP_W,
    parameter int IDX_W   = DEF_IDX_W,
    parameter int IRQ_W   = DEF_IRQ_W,
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int DATA_W  = DEF_DATA_W,
    parameter int IRQ_LSB = DEF_IRQ_LSB,
    parameter int WIN_BIT = DEF_WIN_BIT
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic                               cfg_tsel,
    input  logic [IRQ_W-1:0]                   cfg_addr,
    input  logic [GRP_W-1:0]                   cfg_wdata,
    input  logic [ADDR_W-IRQ_LSB-IRQ_W-1:0]    msi_hi_page,
    input  logic                               req_valid,
    input  logic [1:0]                         req_kind,
    input  logic [RID_W-1:0]                   req_rid,
    input  logic [ADDR_W-1:0]                  req_addr,
    input  logic [DATA_W-1:0]                  req_data,
    output logic                               res_valid,
    output logic [1:0]                         res_kind,
    output logic [GRP_W-1:0]                   res_group,
    output logic                               res_win,
    output logic                               res_msi,
    output logic [IRQ_W-1:0]                   res_irq,
    output logic                               res_auth,
    output logic                               viol_flag,
    output logic [RID_W-1:0]                   viol_rid,
    output logic [IRQ_W-1:0]                   viol_irq
);
    logic             rid_we;
    logic             desc_we;
    logic [GRP_W-1:0] rid_grp;
    logic [GRP_W-1:0] own_grp;
    logic             dec_msg;
    logic             dec_msi;
    logic             dec_win;
    logic [IRQ_W-1:0] dec_irq;
    logic             owner_ok;
    logic             reject;

    // Steer the write port to one of the two tables.
    always_comb begin
        rid_we  = cfg_we && !cfg_tsel;
        desc_we = cfg_we &&  cfg_tsel;
    end

    rga_group_table #(
        .IDX_W (IDX_W),
        .DAT_W (GRP_W)
    ) u_rid_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (rid_we),
        .wr_idx (cfg_addr[IDX_W-1:0]),
        .wr_dat (cfg_wdata),
        .rd_idx (req_rid[IDX_W-1:0]),
        .rd_dat (rid_grp)
    );

    rga_addr_decode #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .IRQ_W   (IRQ_W),
        .IRQ_LSB (IRQ_LSB),
        .WIN_BIT (WIN_BIT)
    ) u_dec (
        .kind    (req_kind),
        .addr    (req_addr),
        .data    (req_data),
        .hi_page (msi_hi_page),
        .is_msg  (dec_msg),
        .is_msi  (dec_msi),
        .win_sel (dec_win),
        .irq     (dec_irq)
    );

    rga_group_table #(
        .IDX_W (IRQ_W),
        .DAT_W (GRP_W)
    ) u_desc_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (desc_we),
        .wr_idx (cfg_addr),
        .wr_dat (cfg_wdata),
        .rd_idx (dec_irq),
        .rd_dat (own_grp)
    );

    // Ownership check: only MSIs can be refused.
    always_comb begin
        owner_ok = (own_grp == rid_grp);
        reject   = req_valid && dec_msi && !owner_ok;
    end

    rga_viol_log #(
        .RID_W (RID_W),
        .IRQ_W (IRQ_W)
    ) u_viol (
        .clk    (clk),
        .rst_n  (rst_n),
        .reject (reject),
        .rid    (req_rid),
        .irq    (dec_irq),
        .flag   (viol_flag),
        .rid_q  (viol_rid),
        .irq_q  (viol_irq)
    );

    // Result register: one entry per request, cleared on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            res_valid <= 1'b0;
            res_kind  <= '0;
            res_group <= '0;
            res_win   <= 1'b0;
            res_msi   <= 1'b0;
            res_irq   <= '0;
            res_auth  <= 1'b0;
        end else begin
            res_valid <= 1'b1;
            res_kind  <= req_kind;
            res_group <= rid_grp;
            res_win   <= dec_win && !dec_msg;
            res_msi   <= dec_msi;
            res_irq   <= dec_irq;
            res_auth  <= !dec_msi || owner_ok;
        end
    end

endmodule

// File: rtl/req_group_auth_chk.sv
// Module: req_group_auth_chk
// Cycle-by-cycle properties of the authorization block, bound to the top.
module req_group_auth_chk #(
    parameter int RID_W   = 16,
    parameter int IRQ_W   = 11,
    parameter int ADDR_W  = 64,
    parameter int WIN_BIT = 59
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              res_valid,
    input logic [1:0]        res_kind,
    input logic              res_win,
    input logic              res_msi,
    input logic [IRQ_W-1:0]  res_irq,
    input logic              res_auth,
    input logic              viol_flag,
    input logic [RID_W-1:0]  viol_rid,
    input logic [IRQ_W-1:0]  viol_irq
);
    // R10: result strobe trails the request strobe by one clock
    p_valid_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    p_idle_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
    // R10: no interrupt number outside MSIs
    p_irq_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !res_msi |-> res_irq == '0);
    // R4: DMA always authorized
    p_dma_auth_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_msi) |-> res_auth);
    // R4: window follows address bit of the request one clock earlier
    p_win_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_msi && !res_kind[1]) |-> res_win == $past(req_addr[WIN_BIT]));
    // R5: reads are never MSIs
    p_read_not_msi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == 2'b00) |-> !res_msi);
    // R8: messages carry no window, no MSI, and pass
    p_msg_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind[1]) |-> (!res_msi && !res_win && res_auth));
    // R9: a rejected MSI result is accompanied by the flag
    p_reject_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_msi && !res_auth) |-> viol_flag);
    // R9: flag is sticky
    p_viol_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag |=> viol_flag);
    // R9: captured details never change once set
    p_viol_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag |=> ($stable(viol_rid) && $stable(viol_irq)));

endmodule

bind req_group_auth req_group_auth_chk #(
    .RID_W   (RID_W),
    .IRQ_W   (IRQ_W),
    .ADDR_W  (ADDR_W),
    .WIN_BIT (WIN_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .res_valid (res_valid),
    .res_kind  (res_kind),
    .res_win   (res_win),
    .res_msi   (res_msi),
    .res_irq   (res_irq),
    .res_auth  (res_auth),
    .viol_flag (viol_flag),
    .viol_rid  (viol_rid),
    .viol_irq  (viol_irq)
);

// File: tb/test_req_group_auth.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected results, a monitor pops
// and compares them two nanoseconds after each rising edge.
module test_req_group_auth;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_tsel = 1'b0;
    logic [10:0] cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [47:0] msi_hi_page = 48'h0000_0040_0001;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [15:0] req_rid = '0;
    logic [63:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic        res_valid;
    logic [1:0]  res_kind;
    logic [7:0]  res_group;
    logic        res_win;
    logic        res_msi;
    logic [10:0] res_irq;
    logic        res_auth;
    logic        viol_flag;
    logic [15:0] viol_rid;
    logic [10:0] viol_irq;

    always #4 clk = ~clk;

    req_group_auth i_req_group_auth (.*);

    typedef struct {
        string       tag;
        logic [1:0]  kind;
        logic [7:0]  grp;
        logic        win;
        logic        msi;
        logic [10:0] irq;
        logic        auth;
        logic        vf;
        logic [15:0] vr;
        logic [10:0] vi;
    } exp_t;

    exp_t sbq[$];
    int total = 0;
    int bad = 0;
    bit timeout = 0;

    // Reference state built from the requirements.
    logic [7:0]  m_rid  [256];
    logic [7:0]  m_desc [2048];
    logic        m_vf = 1'b0;
    logic [15:0] m_vr = '0;
    logic [10:0] m_vi = '0;

    task automatic chk(string req, string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s (%s): actual %0h expected %0h", req, tag, act, exp);
        end
    endtask

    // Build and push the expected result; drive the request pins.
    task automatic put_req(logic [1:0] k, logic [15:0] rid, logic [63:0] a,
                           logic [31:0] d, string tag);
        exp_t e;
        logic msi;
        msi = (k == 2'b01) &&
              (a[63:16] == 48'h0000_0000_FFFF || a[63:16] == msi_hi_page);
        e.tag  = tag;
        e.kind = k;
        e.grp  = m_rid[rid[7:0]];
        e.msi  = msi;
        e.irq  = msi ? 11'((a[15:5] + d) % 2048) : 11'd0;
        e.win  = (!k[1] && !msi) ? a[59] : 1'b0;
        e.auth = msi ? (m_desc[e.irq] == e.grp) : 1'b1;
        if (msi && !e.auth && !m_vf) begin
            m_vf = 1'b1;
            m_vr = rid;
            m_vi = e.irq;
        end
        e.vf = m_vf;
        e.vr = m_vr;
        e.vi = m_vi;
        sbq.push_back(e);
        req_valid = 1'b1;
        req_kind  = k;
        req_rid   = rid;
        req_addr  = a;
        req_data  = d;
    endtask

    task automatic do_req(logic [1:0] k, logic [15:0] rid, logic [63:0] a,
                          logic [31:0] d, string tag);
        @(negedge clk);
        cfg_we = 1'b0;
        put_req(k, rid, a, d, tag);
    endtask

    task automatic set_cfg(logic sel, logic [10:0] ad, logic [7:0] dat);
        cfg_we    = 1'b1;
        cfg_tsel  = sel;
        cfg_addr  = ad;
        cfg_wdata = dat;
    endtask

    task automatic model_wr(logic sel, logic [10:0] ad, logic [7:0] dat);
        if (sel) m_desc[ad] = dat;
        else     m_rid[ad[7:0]] = dat;
    endtask

    task automatic cfg_wr(logic sel, logic [10:0] ad, logic [7:0] dat);
        @(negedge clk);
        req_valid = 1'b0;
        set_cfg(sel, ad, dat);
        model_wr(sel, ad, dat);
    endtask

    // Write and lookup in one cycle: expectation uses the old entry.
    task automatic wr_and_req(logic sel, logic [10:0] ad, logic [7:0] dat,
                              logic [1:0] k, logic [15:0] rid, logic [63:0] a,
                              string tag);
        @(negedge clk);
        set_cfg(sel, ad, dat);
        put_req(k, rid, a, 32'd0, tag);
        model_wr(sel, ad, dat);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we    = 1'b0;
    endtask

    // Monitor: compare each result against the queue front.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && res_valid) begin
                if (sbq.size() == 0) begin
                    chk("R10", "unexpected result", 64'(res_valid), 64'd0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk("R10", e.tag, 64'(res_kind), 64'(e.kind));
                    chk("R2", e.tag, 64'(res_group), 64'(e.grp));
                    chk("R4", e.tag, 64'(res_win), 64'(e.win));
                    chk("R5", e.tag, 64'(res_msi), 64'(e.msi));
                    chk("R6", e.tag, 64'(res_irq), 64'(e.irq));
                    chk("R7", e.tag, 64'(res_auth), 64'(e.auth));
                    chk("R9", e.tag, 64'(viol_flag), 64'(e.vf));
                    chk("R9", e.tag, 64'(viol_rid), 64'(e.vr));
                    chk("R9", e.tag, 64'(viol_irq), 64'(e.vi));
                end
            end else if (rst_n && sbq.size() != 0) begin
                void'(sbq.pop_front());
                chk("R10", "missing result", 64'(res_valid), 64'd1);
            end
        end
    end

    task automatic run_all();
        logic [15:0] rids [8];
        for (int i = 0; i < 256; i++) m_rid[i] = '0;
        for (int i = 0; i < 2048; i++) m_desc[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        // R1: reset state
        chk("R1", "reset valid", 64'(res_valid), 64'd0);
        chk("R1", "reset group", 64'(res_group), 64'd0);
        chk("R1", "reset auth", 64'(res_auth), 64'd0);
        chk("R1", "reset flag", 64'(viol_flag), 64'd0);
        // R1: untouched table entry resolves to group 0
        do_req(2'b00, 16'h0123, 64'h0, 32'd0, "R1 empty table");
        // R2 / R4: lookup after write, bit 59 set on a read
        cfg_wr(1'b0, 11'h023, 8'h5A);
        do_req(2'b00, 16'h0123, 64'h0800_0000_0000_1000, 32'd0, "R2 R4 read win1");
        do_req(2'b01, 16'h0123, 64'h0000_0000_1234_0000, 32'd0, "R4 write win0");
        // R5 R6 R7: low-window MSI owned by the requester's group
        cfg_wr(1'b1, 11'h0AB, 8'h5A);
        do_req(2'b01, 16'h0123, 64'h0000_0000_FFFF_1400, 32'h0B, "R7 owned MSI");
        // R6 wrap and R9 first rejection through the high window
        cfg_wr(1'b0, 11'h077, 8'h11);
        do_req(2'b01, 16'h3477, {48'h0000_0040_0001, 16'hFFE0}, 32'h5, "R6 wrap R9 first");
        // R9: second rejection leaves capture unchanged
        do_req(2'b01, 16'h0123, 64'h0000_0000_FFFF_0200, 32'h0, "R9 second reject");
        // R5: read to an MSI address stays DMA
        do_req(2'b00, 16'h0123, 64'h0000_0000_FFFF_1400, 32'h0B, "R5 read in window");
        // R8: error messages of both encodings
        do_req(2'b10, 16'h0123, 64'h0800_0000_FFFF_0000, 32'h0, "R8 message");
        do_req(2'b11, 16'h3477, 64'h0800_0000_0000_0000, 32'h1, "R8 message alt");
        // R3: same-cycle write and lookup, then next-cycle lookup
        wr_and_req(1'b0, 11'h099, 8'h42, 2'b00, 16'h0099, 64'h0, "R3 same cycle old");
        do_req(2'b00, 16'h0099, 64'h0, 32'd0, "R3 next cycle new");
        // R3: descriptor write reaches MSI check
        cfg_wr(1'b1, 11'h010, 8'h42);
        do_req(2'b01, 16'h0099, 64'h0000_0000_FFFF_0200, 32'h0, "R3 R7 desc write");
        // R10: idle cycle yields no result
        idle();
        @(posedge clk);
        #2;
        chk("R10", "idle valid", 64'(res_valid), 64'd0);
        chk("R10", "idle irq", 64'(res_irq), 64'd0);
        // Mixed traffic over a small requester set.
        for (int i = 0; i < 8; i++) begin
            rids[i] = 16'($urandom);
            cfg_wr(1'b0, 11'(rids[i][7:0]), 8'($urandom_range(0, 3)));
        end
        for (int n = 0; n < 400; n++) begin
            int sel;
            logic [63:0] a;
            sel = $urandom_range(0, 9);
            if (sel == 0) begin
                cfg_wr(1'b1, 11'($urandom), 8'($urandom_range(0, 3)));
            end else begin
                if (sel < 4)      a = {32'h0, 16'hFFFF, 16'($urandom)};
                else if (sel < 6) a = {msi_hi_page, 16'($urandom)};
                else              a = {32'($urandom), 32'($urandom)};
                do_req(2'($urandom), rids[$urandom_range(0, 7)], a,
                       32'($urandom), "R2 R6 R7 mixed");
            end
        end
        idle();
        repeat (3) @(posedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) begin
            total++;
            bad++;
            $display("FAIL R10: watchdog expired, actual running expected finished");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule